// File: doc/BRIEF.md
# Cascaded Interrupt Controller

This block merges 32 main interrupt lines and eleven secondary lines into one interrupt request for a processor. Each main line is captured in a source-pending register, and a mask register decides which pending lines may compete for service. The winner of a fixed, lowest-index-first selection is copied into a one-hot in-service register, and `irq_o` follows that register.

Secondary lines are captured in their own pending register and gated by their own mask. They form four groups: three serial channels with receive, transmit and error lines, and one touch/converter pair. Each group folds into a single parent position of the main pending register. The parent position stays asserted while any unmasked member of its group is pending.

All registers sit behind a plain write-strobe/address port with a combinational read path. Pending and in-service bits are cleared by writing ones. The main and secondary inputs are expected to be synchronous to `clk_i` already.

Top module: `cascade_intc`

## Requirements
- R1: After reset, the main mask reads 0xFFFFFFFF, the secondary mask reads 0x7FF, the pending and in-service registers read 0, and `irq_o` is low.
- R2: A main input that is high at a clock edge sets its pending bit at that edge. The bit stays set after the input returns low.
- R3: Writing 1 to a pending bit clears it at the next edge, and writing 0 has no effect. An input that is high in the same cycle wins over the clear.
- R4: A main mask bit of 1 keeps its pending source out of service and off `irq_o`. The pending bit is still recorded.
- R5: Main positions 6 and 24 never become pending.
- R6: A high secondary input latches into the secondary pending register, and that register is cleared by writing 1. Bit layout: serial channel 0 receive/transmit/error at bits 0/1/2, channel 1 at bits 3/4/5, channel 2 at bits 6/7/8, touch at bit 9, converter at bit 10.
- R7: Bits 0-2 feed parent position 28, bits 3-5 feed 23, bits 6-8 feed 15, and bits 9-10 feed 31. A secondary mask bit of 1 keeps that line from reaching its parent. Main inputs at the four parent positions are ignored.
- R8: A parent pending bit is set at each edge while its group has an unmasked pending member. After a clear it sets again if such a member remains, and it stays clear once none remains.
- R9: The in-service register holds at most one bit. When it is empty, it loads at the next edge the lowest-numbered pending, unmasked main bit. While it is non-empty it never reloads.
- R10: `irq_o` is high exactly while the in-service register is non-zero. Writing 1 to the in-service bit clears it at the next edge.
- R11: Register addresses: 0 source pending, 1 main mask, 2 in-service, 3 secondary pending, 4 secondary mask. The masks are plain read/write registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Main interrupt inputs |
| sub_src_i | input | 11 | Secondary interrupt inputs |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Main lines are pulsed one at a time, in pairs, and all together. The single pulses separate latching from masking. The pairs show that the lowest index wins and that a lower line arriving later does not displace the one in service. The all-ones pulse shows that the reserved and parent positions stay clear. Secondary lines are driven with their masks first closed and then open, which separates group folding from masking. Clearing a parent before and after its member is cleared shows the difference between a parent that re-asserts and one that stays down.

// File: rtl/cintc_pkg.sv
package cintc_pkg;
  localparam int NSRC = 32;
  localparam int NSUB = 11;
  localparam int NGRP = 4;
  localparam int AW   = 3;
  localparam logic [NSRC-1:0] RSVD_BITS = 32'h0100_0040;

  // group layout: low sub bit, width, parent main bit
  localparam int GRP_LO  [NGRP] = '{0, 3, 6, 9};
  localparam int GRP_W   [NGRP] = '{3, 3, 3, 2};
  localparam int GRP_PAR [NGRP] = '{28, 23, 15, 31};

  typedef enum logic [AW-1:0] {
    A_PEND  = 3'd0,
    A_MASK  = 3'd1,
    A_ISR   = 3'd2,
    A_SPEND = 3'd3,
    A_SMASK = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q & ~clr_i) | set_i;
  end

  assign q_o = q_q;

  AST_PEND_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_o & $past(clr_i & ~set_i)) == '0)); // R3

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_o & $past(set_i)) == $past(set_i))); // R2
endmodule

// File: rtl/intc_fold.sv
module intc_fold #(
  parameter int W = 3
) (
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] mask_i,
  output logic         req_o
);
  assign req_o = |(pend_i & ~mask_i);
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int W = 32
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] gnt_o
);
  // isolate lowest set bit
  assign gnt_o = req_i & (~req_i + {{(W-1){1'b0}}, 1'b1});

  always_comb begin
    AST_PICK_ONEHOT: assert ($onehot0(gnt_o)); // R9
  end
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import cintc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSUB-1:0] sub_src_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            irq_o
);
  logic [NSRC-1:0] pend_q, mask_q, isr_q, main_set, main_clr, cand, gnt;
  logic [NSUB-1:0] spend_q, smask_q, sub_clr;
  logic [NGRP-1:0] grp_req;

  logic wr_pend, wr_mask, wr_isr, wr_spend, wr_smask;
  assign wr_pend  = wr_en_i && (addr_i == A_PEND);
  assign wr_mask  = wr_en_i && (addr_i == A_MASK);
  assign wr_isr   = wr_en_i && (addr_i == A_ISR);
  assign wr_spend = wr_en_i && (addr_i == A_SPEND);
  assign wr_smask = wr_en_i && (addr_i == A_SMASK);

  // secondary pending
  assign sub_clr = wr_spend ? wdata_i[NSUB-1:0] : '0;

  intc_pend #(.W(NSUB)) u_spend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sub_src_i),
    .clr_i  (sub_clr),
    .q_o    (spend_q)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    intc_fold #(.W(GRP_W[g])) u_fold (
      .pend_i (spend_q[GRP_LO[g] +: GRP_W[g]]),
      .mask_i (smask_q[GRP_LO[g] +: GRP_W[g]]),
      .req_o  (grp_req[g])
    );

    AST_PARENT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_req[g] |=> pend_q[GRP_PAR[g]]); // R8
  end

  // main set vector: parents come from groups, reserved stay idle
  always_comb begin
    main_set = src_i & ~RSVD_BITS;
    for (int g = 0; g < NGRP; g++) main_set[GRP_PAR[g]] = grp_req[g];
  end

  assign main_clr = wr_pend ? wdata_i : '0;

  intc_pend #(.W(NSRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (main_set),
    .clr_i  (main_clr),
    .q_o    (pend_q)
  );

  // masks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      smask_q <= '1;
    end else begin
      if (wr_mask)  mask_q  <= wdata_i;
      if (wr_smask) smask_q <= wdata_i[NSUB-1:0];
    end
  end

  // selection and in-service
  assign cand = pend_q & ~mask_q;

  intc_pick #(.W(NSRC)) u_pick (
    .req_i (cand),
    .gnt_o (gnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             isr_q <= '0;
    else if (isr_q == '0)    isr_q <= gnt;
    else if (wr_isr)         isr_q <= isr_q & ~wdata_i;
  end

  assign irq_o = |isr_q;

  // read path
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_PEND:  rdata_o = pend_q;
      A_MASK:  rdata_o = mask_q;
      A_ISR:   rdata_o = isr_q;
      A_SPEND: rdata_o[NSUB-1:0] = spend_q;
      A_SMASK: rdata_o[NSUB-1:0] = smask_q;
      default: rdata_o = '0;
    endcase
  end

  AST_RSVD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & RSVD_BITS) == '0); // R5

  AST_ISR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(isr_q)); // R9

  AST_ISR_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_q == '0 && cand != '0) |=> (isr_q != '0)); // R9

  AST_ISR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_q != '0 && !wr_isr) |=> $stable(isr_q)); // R9

  AST_MASKED_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_q == '0) |=> ((isr_q & $past(mask_q)) == '0)); // R4
endmodule

// File: tb/cascade_intc_tb.sv
module cascade_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [10:0] sub_src = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [2:0] RA_PEND = 3'd0, RA_MASK = 3'd1, RA_ISR = 3'd2,
                         RA_SPEND = 3'd3, RA_SMASK = 3'd4;

  always #4 clk = ~clk;

  cascade_intc u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .src_i     (src),
    .sub_src_i (sub_src),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .irq_o     (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic pulse_main(input logic [31:0] v);
    @(negedge clk);
    src = v;
    @(posedge clk);
    @(negedge clk);
    src = '0;
  endtask

  task automatic pulse_sub(input logic [10:0] v);
    @(negedge clk);
    sub_src = v;
    @(posedge clk);
    @(negedge clk);
    sub_src = '0;
  endtask

  task automatic edge1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(RA_MASK, d);  chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(RA_SMASK, d); chk("R1 submask", d, 32'h0000_07FF);
    rd(RA_PEND, d);  chk("R1 pend", d, 0);
    rd(RA_SPEND, d); chk("R1 subpend", d, 0);
    rd(RA_ISR, d);   chk("R1 isr", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_latch;
    logic [31:0] d;
    pulse_main(32'h8);
    rd(RA_PEND, d); chk("R2 latch", d, 32'h8);
    edge1;
    rd(RA_PEND, d); chk("R2 hold", d, 32'h8);
    chk("R4 masked irq", {31'd0, irq}, 0);
    wr(RA_PEND, 32'h0);
    rd(RA_PEND, d); chk("R3 zero write", d, 32'h8);
    wr(RA_PEND, 32'h8);
    rd(RA_PEND, d); chk("R3 clear", d, 0);
    @(negedge clk);
    src = 32'h8; wr_en = 1'b1; addr = RA_PEND; wdata = 32'h8;
    @(posedge clk);
    @(negedge clk);
    src = '0; wr_en = 1'b0; wdata = '0;
    rd(RA_PEND, d); chk("R3 set wins", d, 32'h8);
    wr(RA_PEND, 32'h8);
    rd(RA_PEND, d); chk("R3 clear again", d, 0);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    pulse_main(32'hFFFF_FFFF);
    rd(RA_PEND, d);
    chk("R5 R7 reserved and parent", d,
        ~(32'h0100_0040 | 32'h9080_8000));
    wr(RA_PEND, 32'hFFFF_FFFF);
    rd(RA_PEND, d); chk("R3 bulk clear", d, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    pulse_main(32'h20);
    edge1;
    chk("R4 irq stays low", {31'd0, irq}, 0);
    rd(RA_PEND, d); chk("R4 still pending", d, 32'h20);
    wr(RA_MASK, ~32'h20);
    rd(RA_MASK, d); chk("R11 mask readback", d, ~32'h20);
    edge1;
    rd(RA_ISR, d); chk("R4 unmasked serviced", d, 32'h20);
    wr(RA_PEND, 32'h20);
    wr(RA_ISR, 32'h20);
    wr(RA_MASK, 32'hFFFF_FFFF);
    rd(RA_ISR, d); chk("R10 isr cleared", d, 0);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    wr(RA_MASK, 32'h0);
    pulse_main(32'h210);
    edge1;
    rd(RA_ISR, d); chk("R9 lowest first", d, 32'h10);
    chk("R10 irq high", {31'd0, irq}, 1);
    wr(RA_PEND, 32'h10);
    wr(RA_ISR, 32'h10);
    rd(RA_ISR, d); chk("R10 isr clear", d, 0);
    chk("R10 irq low", {31'd0, irq}, 0);
    pulse_main(32'h4);
    rd(RA_ISR, d); chk("R9 next winner", d, 32'h200);
    edge1;
    rd(RA_ISR, d); chk("R9 no preempt", d, 32'h200);
    wr(RA_PEND, 32'h204);
    wr(RA_ISR, 32'h200);
    edge1;
    rd(RA_ISR, d); chk("R9 empty stays empty", d, 0);
    chk("R10 irq low end", {31'd0, irq}, 0);
    wr(RA_MASK, 32'hFFFF_FFFF);
  endtask

  task automatic t_sub;
    logic [31:0] d;
    wr(RA_MASK, ~(32'h1 << 28));
    pulse_sub(11'h002);
    rd(RA_SPEND, d); chk("R6 sub latch", d, 32'h2);
    edge1;
    rd(RA_PEND, d); chk("R7 submask blocks", d, 0);
    wr(RA_SMASK, 32'h7FD);
    rd(RA_SMASK, d); chk("R11 submask readback", d, 32'h7FD);
    edge1;
    rd(RA_PEND, d); chk("R8 parent set", d, 32'h1 << 28);
    edge1;
    rd(RA_ISR, d); chk("R9 parent serviced", d, 32'h1 << 28);
    wr(RA_PEND, 32'h1 << 28);
    rd(RA_PEND, d); chk("R8 reassert", d, 32'h1 << 28);
    wr(RA_SPEND, 32'h2);
    rd(RA_SPEND, d); chk("R6 sub clear", d, 0);
    wr(RA_PEND, 32'h1 << 28);
    rd(RA_PEND, d); chk("R8 parent cleared", d, 0);
    edge1;
    rd(RA_PEND, d); chk("R8 parent stays clear", d, 0);
    wr(RA_ISR, 32'h1 << 28);
    wr(RA_MASK, 32'hFFFF_FFFF);
    wr(RA_SMASK, 32'h0);
    for (int k = 0; k < 3; k++) begin
      logic [10:0] sb;
      logic [31:0] par;
      sb  = (k == 0) ? 11'h400 : (k == 1) ? 11'h100 : 11'h010;
      par = (k == 0) ? (32'h1 << 31) : (k == 1) ? (32'h1 << 15) : (32'h1 << 23);
      pulse_sub(sb);
      edge1;
      rd(RA_PEND, d); chk("R7 group parent", d, par);
      wr(RA_SPEND, {21'd0, sb});
      wr(RA_PEND, par);
      rd(RA_PEND, d); chk("R7 group cleanup", d, 0);
    end
    wr(RA_SMASK, 32'h7FF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_latch;
    t_reserved;
    t_mask;
    t_priority;
    t_sub;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule